// File: doc/BRIEF.md
# Nested Hardware Loop Controller

This block is the zero-overhead loop unit of a small in-order processor. A loop-start instruction retires with an iteration count, taken from a register operand or from an immediate field, and with a body length. The controller then records a loop frame on a bounded stack. Each frame holds the first body address, the last body address and the number of passes still to run. For every retiring instruction, the controller compares the program counter with the last body address of the innermost frame. At that address it either sends fetch back to the body start, or it drops the frame and lets execution fall through. Several nested loops may close on the same instruction. In that case the controller resolves the whole chain of frames within one cycle.

The controller also raises the architectural loop errors. These are a zero iteration count, a control transfer or loop start placed on the last instruction of the innermost body, a loop start while the stack is full, a body end that lies outside instruction memory, and an inner body that reaches past the end of the loop that encloses it. Any error on a loop start stops the frame from being recorded. A transfer on the last body instruction is flagged, and no loop-end action takes place for that instruction. Redirect and error outputs are combinational on the retire inputs, so the fetch unit can act in the same cycle. The stack is updated at the clock edge.

Top module: `hw_loop_ctrl`

## Requirements
- R1: After reset the stack depth reads 0, and no redirect and no error is raised.
- R2: Retire kind encodes 0 = plain, 1 = branch/jump, 2 = loop with register count, 3 = loop with immediate count. The immediate is zero-extended. A loop with count N runs its body N times: fetch is redirected to the body start on the first N-1 passes of the last body instruction, and the frame is removed on the last pass.
- R3: A loop started at address P with body length field L has a body from P+1 to P+1+L, so L = 0 gives a one-instruction body.
- R4: A count of zero raises the zero-count error, and no frame is recorded.
- R5: A branch/jump or loop start that retires at the innermost frame's last body address raises the end-transfer error. It causes no redirect, and the frame keeps its count.
- R6: A loop start while DEPTH frames are held raises the overflow error, and the depth stays at DEPTH.
- R7: A body end address at or above IMEM_WORDS raises the out-of-range error, and no frame is recorded. An end exactly at IMEM_WORDS-1 is accepted.
- R8: A loop whose body end lies beyond the enclosing frame's end raises the nesting error and is not recorded. This holds when it starts mid-body and when it starts on the outer loop's last instruction (which also raises R5).
- R9: When frames share an end address, every exhausted frame at that address is removed in the same cycle. The next frame that still has passes left redirects to its own start.
- R10: The largest immediate count (all ones) runs exactly that many passes.
- R11: A cycle without a retiring instruction, or a plain instruction away from the innermost end, causes no redirect and leaves the depth unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | AW | Word address of the retiring instruction |
| ret_kind | input | 2 | 0 plain, 1 branch/jump, 2 loop (register count), 3 loop (immediate count) |
| loop_reg_count | input | CW | Iteration count from the register operand |
| loop_imm_count | input | IW | Iteration count from the immediate field |
| loop_body_len | input | BW | Body length minus one |
| redirect_valid | output | 1 | Fetch must continue at redirect_pc |
| redirect_pc | output | AW | Loop body start to fetch next |
| stack_depth | output | $clog2(DEPTH+1) | Number of frames currently held |
| err_zero_count | output | 1 | Loop start with zero count |
| err_at_end | output | 1 | Transfer or loop start on the innermost last body instruction |
| err_overflow | output | 1 | Loop start with a full stack |
| err_bad_nest | output | 1 | Inner body ends past the enclosing body |
| err_end_oob | output | 1 | Body end lies outside instruction memory |

## Verification
Single loops are run with both count sources and with one-instruction and three-instruction bodies. These runs separate the decrement-and-redirect path from the final-pass removal, and they show the end address formula, including the one-past-memory boundary. Nested starts that reach past the outer end from the middle and from the outer last instruction separate the nesting check from the end-transfer check. A stack filled to capacity with eight loops that all share one end address shows both the overflow error and the full cascade removal. A two-level shared end with counts left over shows that the cascade stops at the first frame that still has passes. A run with the largest immediate count shows that the full count range is held without truncation.

// File: rtl/hwl_pkg.sv
package hwl_pkg;

  typedef enum logic [1:0] {
    RK_PLAIN    = 2'd0,
    RK_XFER     = 2'd1,
    RK_LOOP_REG = 2'd2,
    RK_LOOP_IMM = 2'd3
  } ret_kind_e;

  typedef struct packed {
    logic zero_cnt;
    logic at_end;
    logic overflow;
    logic bad_nest;
    logic end_oob;
  } loop_err_t;

endpackage

// File: rtl/hwl_start_check.sv
module hwl_start_check #(
  parameter int AW         = 12,
  parameter int CW         = 32,
  parameter int IW         = 10,
  parameter int BW         = 12,
  parameter int IMEM_WORDS = 1024,
  parameter int DEPTH      = 8,
  localparam int SPW       = $clog2(DEPTH + 1)
) (
  input  logic             is_loop_i,
  input  logic             use_imm_i,
  input  logic [CW-1:0]    reg_cnt_i,
  input  logic [IW-1:0]    imm_cnt_i,
  input  logic [BW-1:0]    body_len_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [SPW-1:0]   depth_i,
  input  logic [AW-1:0]    top_end_i,
  input  logic             at_end_err_i,
  output logic [CW-1:0]    cnt_o,
  output logic [AW-1:0]    start_o,
  output logic [AW-1:0]    end_o,
  output logic             zero_o,
  output logic             overflow_o,
  output logic             bad_nest_o,
  output logic             oob_o,
  output logic             push_o
);

  localparam int EW = ((AW > BW) ? AW : BW) + 2;

  logic [EW-1:0] end_wide;
  logic          any_err;

  always_comb begin
    cnt_o    = use_imm_i ? CW'(imm_cnt_i) : reg_cnt_i;
    end_wide = EW'(pc_i) + EW'(body_len_i) + EW'(1);
    start_o  = pc_i + AW'(1);
    end_o    = end_wide[AW-1:0];

    zero_o     = is_loop_i && (cnt_o == '0);
    overflow_o = is_loop_i && (depth_i == SPW'(DEPTH));
    oob_o      = is_loop_i && (end_wide >= EW'(IMEM_WORDS));
    bad_nest_o = is_loop_i && (depth_i != '0) && (end_wide > EW'(top_end_i));

    any_err = zero_o | overflow_o | oob_o | bad_nest_o | at_end_err_i;
    push_o  = is_loop_i && !any_err;
  end

endmodule

// File: rtl/hwl_end_eval.sv
module hwl_end_eval #(
  parameter int AW    = 12,
  parameter int CW    = 32,
  parameter int DEPTH = 8,
  localparam int SPW  = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic             active_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [SPW-1:0]   depth_i,
  input  logic [AW-1:0]    f_start_i [DEPTH],
  input  logic [AW-1:0]    f_end_i   [DEPTH],
  input  logic [CW-1:0]    f_cnt_i   [DEPTH],
  output logic             redirect_o,
  output logic [AW-1:0]    target_o,
  output logic [SPW-1:0]   pops_o,
  output logic             dec_o,
  output logic [PW-1:0]    dec_idx_o
);

  logic           walk_done;
  logic [SPW-1:0] slot_full;
  logic [PW-1:0]  slot;

  // Walk from the innermost frame outwards while frames close here.
  always_comb begin
    walk_done  = !active_i;
    redirect_o = 1'b0;
    target_o   = '0;
    pops_o     = '0;
    dec_o      = 1'b0;
    dec_idx_o  = '0;
    slot_full  = '0;
    slot       = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (!walk_done && (SPW'(j) < depth_i)) begin
        slot_full = depth_i - SPW'(1) - SPW'(j);
        slot      = slot_full[PW-1:0];
        if (f_end_i[slot] == pc_i) begin
          if (f_cnt_i[slot] == CW'(1)) begin
            pops_o = pops_o + SPW'(1);
          end else begin
            redirect_o = 1'b1;
            target_o   = f_start_i[slot];
            dec_o      = 1'b1;
            dec_idx_o  = slot;
            walk_done  = 1'b1;
          end
        end else begin
          walk_done = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/hwl_frame_stack.sv
module hwl_frame_stack #(
  parameter int AW    = 12,
  parameter int CW    = 32,
  parameter int DEPTH = 8,
  localparam int SPW  = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [AW-1:0]    push_start_i,
  input  logic [AW-1:0]    push_end_i,
  input  logic [CW-1:0]    push_cnt_i,
  input  logic [SPW-1:0]   pops_i,
  input  logic             dec_i,
  input  logic [PW-1:0]    dec_idx_i,
  output logic [SPW-1:0]   depth_o,
  output logic [AW-1:0]    f_start_o [DEPTH],
  output logic [AW-1:0]    f_end_o   [DEPTH],
  output logic [CW-1:0]    f_cnt_o   [DEPTH]
);

  logic [SPW-1:0] sp_q, sp_d;
  logic           sp_en;

  always_comb begin
    sp_en = push_i || (pops_i != '0);
    sp_d  = push_i ? (sp_q + SPW'(1)) : (sp_q - pops_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (sp_en) begin
      sp_q <= sp_d;
    end
  end

  assign depth_o = sp_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_frame
    logic          wr_en;
    logic [AW-1:0] start_q, start_d;
    logic [AW-1:0] end_q, end_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          is_push_slot;
    logic          is_dec_slot;

    always_comb begin
      is_push_slot = push_i && (sp_q == SPW'(g));
      is_dec_slot  = dec_i && (dec_idx_i == PW'(g));
      wr_en        = is_push_slot || is_dec_slot;
      start_d      = is_push_slot ? push_start_i : start_q;
      end_d        = is_push_slot ? push_end_i : end_q;
      cnt_d        = is_push_slot ? push_cnt_i : (cnt_q - CW'(1));
    end

    always_ff @(posedge clk) begin
      if (wr_en) begin
        start_q <= start_d;
        end_q   <= end_d;
        cnt_q   <= cnt_d;
      end
    end

    assign f_start_o[g] = start_q;
    assign f_end_o[g]   = end_q;
    assign f_cnt_o[g]   = cnt_q;
  end

endmodule

// File: rtl/hw_loop_ctrl.sv
module hw_loop_ctrl #(
  parameter int AW         = 12,
  parameter int CW         = 32,
  parameter int IW         = 10,
  parameter int BW         = 12,
  parameter int IMEM_WORDS = 1024,
  parameter int DEPTH      = 8,
  localparam int SPW       = $clog2(DEPTH + 1),
  localparam int PW        = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_valid,
  input  logic [AW-1:0]    ret_pc,
  input  logic [1:0]       ret_kind,
  input  logic [CW-1:0]    loop_reg_count,
  input  logic [IW-1:0]    loop_imm_count,
  input  logic [BW-1:0]    loop_body_len,
  output logic             redirect_valid,
  output logic [AW-1:0]    redirect_pc,
  output logic [SPW-1:0]   stack_depth,
  output logic             err_zero_count,
  output logic             err_at_end,
  output logic             err_overflow,
  output logic             err_bad_nest,
  output logic             err_end_oob
);

  import hwl_pkg::*;

  ret_kind_e     kind;
  logic          is_loop;
  logic [SPW-1:0] depth;
  logic [PW-1:0] top_idx;
  logic [SPW-1:0] top_full;
  logic [AW-1:0] top_end;
  logic          at_top_end;
  loop_err_t     errs;

  logic [AW-1:0] f_start [DEPTH];
  logic [AW-1:0] f_end   [DEPTH];
  logic [CW-1:0] f_cnt   [DEPTH];

  logic [CW-1:0] new_cnt;
  logic [AW-1:0] new_start, new_end;
  logic          push;
  logic          end_active;
  logic [SPW-1:0] pops;
  logic          dec;
  logic [PW-1:0] dec_idx;

  always_comb begin
    kind       = ret_kind_e'(ret_kind);
    is_loop    = ret_valid && ((kind == RK_LOOP_REG) || (kind == RK_LOOP_IMM));
    top_full   = depth - SPW'(1);
    top_idx    = top_full[PW-1:0];
    top_end    = f_end[top_idx];
    at_top_end = (depth != '0) && (top_end == ret_pc);
    errs.at_end = ret_valid && (kind != RK_PLAIN) && at_top_end;
    end_active  = ret_valid && !errs.at_end;
  end

  hwl_start_check #(
    .AW(AW), .CW(CW), .IW(IW), .BW(BW),
    .IMEM_WORDS(IMEM_WORDS), .DEPTH(DEPTH)
  ) u_start (
    .is_loop_i    (is_loop),
    .use_imm_i    (kind == RK_LOOP_IMM),
    .reg_cnt_i    (loop_reg_count),
    .imm_cnt_i    (loop_imm_count),
    .body_len_i   (loop_body_len),
    .pc_i         (ret_pc),
    .depth_i      (depth),
    .top_end_i    (top_end),
    .at_end_err_i (errs.at_end),
    .cnt_o        (new_cnt),
    .start_o      (new_start),
    .end_o        (new_end),
    .zero_o       (errs.zero_cnt),
    .overflow_o   (errs.overflow),
    .bad_nest_o   (errs.bad_nest),
    .oob_o        (errs.end_oob),
    .push_o       (push)
  );

  hwl_end_eval #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_eval (
    .active_i   (end_active),
    .pc_i       (ret_pc),
    .depth_i    (depth),
    .f_start_i  (f_start),
    .f_end_i    (f_end),
    .f_cnt_i    (f_cnt),
    .redirect_o (redirect_valid),
    .target_o   (redirect_pc),
    .pops_o     (pops),
    .dec_o      (dec),
    .dec_idx_o  (dec_idx)
  );

  hwl_frame_stack #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_stack (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (push),
    .push_start_i (new_start),
    .push_end_i   (new_end),
    .push_cnt_i   (new_cnt),
    .pops_i       (pops),
    .dec_i        (dec),
    .dec_idx_i    (dec_idx),
    .depth_o      (depth),
    .f_start_o    (f_start),
    .f_end_o      (f_end),
    .f_cnt_o      (f_cnt)
  );

  assign stack_depth    = depth;
  assign err_zero_count = errs.zero_cnt;
  assign err_at_end     = errs.at_end;
  assign err_overflow   = errs.overflow;
  assign err_bad_nest   = errs.bad_nest;
  assign err_end_oob    = errs.end_oob;

endmodule

// File: rtl/hw_loop_ctrl_chk.sv
module hw_loop_ctrl_chk #(
  parameter int AW    = 12,
  parameter int DEPTH = 8,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ret_valid,
  input logic [1:0]     ret_kind,
  input logic           redirect_valid,
  input logic [SPW-1:0] stack_depth,
  input logic           err_zero_count,
  input logic           err_at_end,
  input logic           err_overflow,
  input logic           err_bad_nest,
  input logic           err_end_oob
);

  logic any_err;
  assign any_err = err_zero_count | err_at_end | err_overflow | err_bad_nest | err_end_oob;

  assert_redirect_on_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (ret_valid && (ret_kind == 2'd0)));

  assert_clean_start_pushes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_kind[1] && !any_err) |=> (stack_depth == $past(stack_depth) + SPW'(1)));

  assert_zero_count_no_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_kind[1] && err_zero_count) |=> $stable(stack_depth));

  assert_end_xfer_no_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_at_end |-> (!redirect_valid && ret_kind != 2'd0));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |-> (stack_depth == SPW'(DEPTH)));

  assert_depth_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stack_depth <= SPW'(DEPTH));

  assert_oob_no_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && err_end_oob) |=> $stable(stack_depth));

  assert_bad_nest_no_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && err_bad_nest) |=> $stable(stack_depth));

  assert_redirect_no_growth_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (stack_depth <= $past(stack_depth)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |-> (!redirect_valid && !any_err));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |=> $stable(stack_depth));

endmodule

bind hw_loop_ctrl hw_loop_ctrl_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ret_valid      (ret_valid),
  .ret_kind       (ret_kind),
  .redirect_valid (redirect_valid),
  .stack_depth    (stack_depth),
  .err_zero_count (err_zero_count),
  .err_at_end     (err_at_end),
  .err_overflow   (err_overflow),
  .err_bad_nest   (err_bad_nest),
  .err_end_oob    (err_end_oob)
);

// File: tb/hw_loop_ctrl_test.sv
`timescale 1ns/1ps
module hw_loop_ctrl_test;

  localparam int AW = 12, CW = 32, IW = 10, BW = 12, DEPTH = 8;
  localparam int SPW = $clog2(DEPTH + 1);
  // error vector order: zero, at_end, overflow, bad_nest, oob
  localparam logic [4:0] E_NONE = 5'b00000, E_ZERO = 5'b10000, E_END = 5'b01000,
                         E_OVF = 5'b00100, E_NEST = 5'b00010, E_OOB = 5'b00001;

  logic clk = 1'b0;
  logic rst_n;
  logic ret_valid;
  logic [AW-1:0] ret_pc;
  logic [1:0] ret_kind;
  logic [CW-1:0] loop_reg_count;
  logic [IW-1:0] loop_imm_count;
  logic [BW-1:0] loop_body_len;
  logic redirect_valid;
  logic [AW-1:0] redirect_pc;
  logic [SPW-1:0] stack_depth;
  logic err_zero_count, err_at_end, err_overflow, err_bad_nest, err_end_oob;

  always #2 clk = ~clk;

  hw_loop_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
    .ret_kind(ret_kind), .loop_reg_count(loop_reg_count),
    .loop_imm_count(loop_imm_count), .loop_body_len(loop_body_len),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .stack_depth(stack_depth), .err_zero_count(err_zero_count),
    .err_at_end(err_at_end), .err_overflow(err_overflow),
    .err_bad_nest(err_bad_nest), .err_end_oob(err_end_oob)
  );

  typedef struct {
    logic       rv;
    int         rpc;
    logic [4:0] err;
    int         dep;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;

  task automatic step(input logic v, input logic [1:0] k, input int pc, input int rc,
                      input int ic, input int bl, input logic erv, input int erpc,
                      input logic [4:0] eerr, input int edep, input string tag);
    exp_t e;
    @(negedge clk);
    ret_valid      = v;
    ret_kind       = k;
    ret_pc         = AW'(pc);
    loop_reg_count = CW'(rc);
    loop_imm_count = IW'(ic);
    loop_body_len  = BW'(bl);
    e.rv = erv; e.rpc = erpc; e.err = eerr; e.dep = edep; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic plain(input int pc, input logic erv, input int erpc, input int edep, input string tag);
    step(1'b1, 2'd0, pc, 0, 0, 0, erv, erpc, E_NONE, edep, tag);
  endtask
  task automatic xfer(input int pc, input logic [4:0] eerr, input int edep, input string tag);
    step(1'b1, 2'd1, pc, 0, 0, 0, 1'b0, 0, eerr, edep, tag);
  endtask
  task automatic lreg(input int pc, input int rc, input int bl, input logic [4:0] eerr, input int edep, input string tag);
    step(1'b1, 2'd2, pc, rc, 0, bl, 1'b0, 0, eerr, edep, tag);
  endtask
  task automatic limm(input int pc, input int ic, input int bl, input logic [4:0] eerr, input int edep, input string tag);
    step(1'b1, 2'd3, pc, 0, ic, bl, 1'b0, 0, eerr, edep, tag);
  endtask
  task automatic idle(input int pc, input int edep, input string tag);
    step(1'b0, 2'd0, pc, 0, 0, 0, 1'b0, 0, E_NONE, edep, tag);
  endtask

  // Monitor: compares one queued expectation per cycle, between edges.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        logic [4:0] got_err;
        e = exp_q.pop_front();
        got_err = {err_zero_count, err_at_end, err_overflow, err_bad_nest, err_end_oob};
        n_tests++;
        if (redirect_valid !== e.rv || (e.rv && int'(redirect_pc) != e.rpc) ||
            got_err !== e.err || int'(stack_depth) != e.dep) begin
          n_fail++;
          $display("FAIL %s: actual rv=%0b pc=%0d err=%b depth=%0d expected rv=%0b pc=%0d err=%b depth=%0d",
                   e.tag, redirect_valid, redirect_pc, got_err, stack_depth,
                   e.rv, e.rpc, e.err, e.dep);
        end
      end
    end
  end

  initial begin
    ret_valid = 0; ret_kind = 0; ret_pc = 0;
    loop_reg_count = 0; loop_imm_count = 0; loop_body_len = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    idle(0, 0, "R1 reset state");

    // R2/R3: register count 3, body 11..13
    lreg(10, 3, 2, E_NONE, 0, "R2 reg loop start");
    for (int it = 0; it < 3; it++) begin
      plain(11, 0, 0, 1, "R11 body plain");
      plain(12, 0, 0, 1, "R11 body plain");
      plain(13, it < 2, 11, 1, "R2 R3 loop end");
    end
    idle(0, 0, "R2 frame removed");

    // R3 one-instruction body, immediate count 2; R11 idle at end pc
    limm(20, 2, 0, E_NONE, 0, "R2 imm loop start");
    idle(21, 1, "R11 no retire at end");
    plain(21, 1, 21, 1, "R3 single body redirect");
    plain(21, 0, 0, 1, "R3 single body last pass");
    plain(22, 0, 0, 0, "R3 fall through");

    // R4 zero counts
    lreg(30, 0, 3, E_ZERO, 0, "R4 zero reg count");
    limm(30, 0, 3, E_ZERO, 0, "R4 zero imm count");
    idle(0, 0, "R4 nothing recorded");

    // R7 end range
    limm(1000, 1, 23, E_OOB, 0, "R7 end one past memory");
    idle(0, 0, "R7 nothing recorded");
    limm(1000, 1, 22, E_NONE, 0, "R7 end at last word");
    plain(1023, 0, 0, 1, "R7 last word loop end");
    idle(0, 0, "R7 frame removed");

    // R8 bad nesting, outer body 41..50 count 2
    limm(40, 2, 9, E_NONE, 0, "R8 outer start");
    lreg(42, 5, 10, E_NEST, 1, "R8 inner past end from middle");
    limm(50, 5, 5, E_NEST | E_END, 1, "R8 R5 inner start on outer end");
    plain(50, 1, 41, 1, "R8 outer still counts");
    plain(50, 0, 0, 1, "R8 outer last pass");
    idle(0, 0, "R8 frame removed");

    // R5 transfer at end, body 61..64
    limm(60, 2, 3, E_NONE, 0, "R5 loop start");
    xfer(64, E_END, 1, "R5 branch at end");
    xfer(62, E_NONE, 1, "R5 branch mid body");
    plain(64, 1, 61, 1, "R5 count untouched");
    plain(64, 0, 0, 1, "R5 last pass");
    idle(0, 0, "R5 frame removed");

    // R9 shared end 76: outer 71.. count 2, inner 73.. count 3
    limm(70, 2, 5, E_NONE, 0, "R9 outer start");
    for (int o = 0; o < 2; o++) begin
      limm(72, 3, 3, E_NONE, 1, "R9 inner start");
      plain(76, 1, 73, 2, "R9 inner redirect");
      plain(76, 1, 73, 2, "R9 inner redirect");
      plain(76, o == 0, 71, 2, "R9 shared end cascade");
    end
    idle(0, 0, "R9 all removed");

    // R6 fill stack, all ending at 200
    for (int i = 0; i < DEPTH; i++) limm(100 + i, 1, 99 - i, E_NONE, i, "R6 fill");
    limm(108, 1, 10, E_OVF, DEPTH, "R6 overflow");
    idle(0, DEPTH, "R6 depth held at full");
    plain(200, 0, 0, DEPTH, "R9 R6 full cascade");
    idle(0, 0, "R9 all frames removed");

    // R10 maximum immediate count
    limm(300, (1 << IW) - 1, 0, E_NONE, 0, "R10 max count start");
    for (int p = 0; p < (1 << IW) - 1; p++)
      plain(301, p < (1 << IW) - 2, 301, 1, "R10 max count pass");
    idle(0, 0, "R10 frame removed");

    wait (exp_q.size() == 0);
    @(negedge clk); #2;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual run still busy expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule